// File: doc/BRIEF.md
# Relocatable Index/Data Register Port

This block lets a host reach a small bank of internal byte registers through two adjacent I/O addresses. The host first writes a register number to the index port, then reads or writes the data port, which sits one address above the index port. The index port itself reads back whatever was last written to it. Register numbers 1 through 15 select bank entries. Any other number reads back zero through the data port, and writes to it are dropped.

The base address of the port pair is relocatable. While the chip is in configuration mode, the base can be set to one of four legal values: 0xE0, 0xE2, 0xE4 or 0xEA. Any other value is refused. A newly set base is held as pending and does not move the decoder until configuration mode ends. During configuration mode the decoder keeps answering at the old committed base.

Decoding is gated by a run enable input. A separate configuration-side path can read the bank at any time, and can write it only while configuration mode is active. It does not use the index register.

Top module: `regport_top`

## Requirements
- R1: After a synchronous active-high reset, both the committed base and the pending base are 0xEA, the index register is 0x00 and every bank entry is 0x00.
- R2: The index port sits at the committed base and the data port at committed base + 1. A read of the index port returns the last byte written to it.
- R3: With the index holding 1..15, a data port write stores the byte in that bank entry, and a data port read returns that entry.
- R4: With the index holding 0x00 or any value of 0x10 and above (0x13 included), data port reads return 0x00 and data port writes change no entry.
- R5: While run_en is 0, the port ignores reads and writes at both addresses: io_rdata is 0x00, io_hit is 0, and no state changes.
- R6: A base write through base_prog_we is accepted only while cfg_mode is 1 and only for the values 0xE0, 0xE2, 0xE4 or 0xEA. Otherwise the pending base keeps its value.
- R7: While cfg_mode is 1, the committed base holds its value and the decoder keeps answering at it. On the first clock edge with cfg_mode at 0, the committed base takes the pending value.
- R8: The configuration path reads entry cfg_idx (4 bits) on cfg_rdata at any time; cfg_idx 0 reads 0x00. It writes an entry only while cfg_mode is 1, and cfg_idx 0 stores nothing.
- R9: If the data port and the configuration path write the same entry in one cycle, the configuration value is stored. Writes to different entries in one cycle both land.
- R10: io_hit is 1 only for a read or write at a decoded address. io_rdata is 0x00 whenever no decoded read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | 8 | Read data for a decoded host read, otherwise 0 |
| io_hit | output | 1 | Host access decoded at index or data port |
| run_en | input | 1 | Global enable for the port pair |
| cfg_mode | input | 1 | Configuration mode active |
| base_prog_we | input | 1 | Base programming strobe |
| base_prog_val | input | 8 | Requested index port base |
| cfg_we | input | 1 | Configuration path write strobe |
| cfg_idx | input | 4 | Configuration path entry number |
| cfg_wdata | input | 8 | Configuration path write data |
| cfg_rdata | output | 8 | Configuration path read data |

## Verification
The bench builds the block with its default parameters: 8-bit addresses and data, 15 entries, four legal bases and a reset base of 0xEA. With 15 entries the 4-bit entry number leaves exactly one unused code (0), so the zero index is covered. The 8-bit index byte makes 0x13 a useful value: its low nibble aliases entry 3, so it shows that out-of-range indices are judged on the full byte. Moving the base between three of the four legal values, and offering one illegal value, covers both the held-pending window and the commit edge.

// File: rtl/regport_pkg.sv
package regport_pkg;
    localparam int DEF_AW     = 8;
    localparam int DEF_DW     = 8;
    localparam int DEF_NREGS  = 15;
    localparam logic [7:0] DEF_BASE_RST = 8'hEA;
    localparam logic [7:0] DEF_BASE_A   = 8'hE0;
    localparam logic [7:0] DEF_BASE_B   = 8'hE2;
    localparam logic [7:0] DEF_BASE_C   = 8'hE4;
    localparam logic [7:0] DEF_BASE_D   = 8'hEA;
endpackage

// File: rtl/regport_base.sv
module regport_base #(
    parameter int              AW       = regport_pkg::DEF_AW,
    parameter logic [AW-1:0]   BASE_RST = regport_pkg::DEF_BASE_RST,
    parameter logic [AW-1:0]   BASE_A   = regport_pkg::DEF_BASE_A,
    parameter logic [AW-1:0]   BASE_B   = regport_pkg::DEF_BASE_B,
    parameter logic [AW-1:0]   BASE_C   = regport_pkg::DEF_BASE_C,
    parameter logic [AW-1:0]   BASE_D   = regport_pkg::DEF_BASE_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_mode,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_val,
    output logic [AW-1:0] cur_base
);
    typedef struct packed {
        logic [AW-1:0] cur;
        logic [AW-1:0] pend;
    } base_st_t;

    base_st_t st_d, st_q;
    logic     legal;

    always_comb begin
        legal = (prog_val == BASE_A) || (prog_val == BASE_B) ||
                (prog_val == BASE_C) || (prog_val == BASE_D);
        st_d = st_q;
        if (cfg_mode && prog_we && legal) begin
            st_d.pend = prog_val;
        end
        if (!cfg_mode) begin
            st_d.cur = st_q.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cur  <= BASE_RST;
            st_q.pend <= BASE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_base = st_q.cur;

    // R6
    pend_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend == BASE_A) || (st_q.pend == BASE_B) ||
        (st_q.pend == BASE_C) || (st_q.pend == BASE_D));

    // R7
    cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_mode) && !$past(rst)) |-> $stable(st_q.cur));
endmodule

// File: rtl/regport_bank.sv
module regport_bank #(
    parameter int DW    = regport_pkg::DEF_DW,
    parameter int NREGS = regport_pkg::DEF_NREGS,
    localparam int IW   = $clog2(NREGS + 1),
    localparam int NSLOT = 1 << IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          port_we,
    input  logic [IW-1:0] port_idx,
    input  logic [DW-1:0] port_wdata,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] port_rdata,
    output logic [DW-1:0] cfg_rdata
);
    logic [DW-1:0] slot [NSLOT];

    for (genvar e = 0; e < NSLOT; e++) begin : g_ent
        if (e >= 1 && e <= NREGS) begin : g_live
            logic [DW-1:0] ent_d, ent_q;

            always_comb begin
                ent_d = ent_q;
                if (port_we && port_idx == IW'(e)) ent_d = port_wdata;
                if (cfg_we && cfg_idx == IW'(e))   ent_d = cfg_wdata;
            end

            always_ff @(posedge clk) begin
                if (rst) ent_q <= '0;
                else     ent_q <= ent_d;
            end

            assign slot[e] = ent_q;

            // R9
            cfg_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (cfg_we && cfg_idx == IW'(e)) |=> (ent_q == $past(cfg_wdata)));
        end else begin : g_dead
            assign slot[e] = '0;
        end
    end

    assign port_rdata = slot[port_idx];
    assign cfg_rdata  = slot[cfg_idx];
endmodule

// File: rtl/regport_top.sv
module regport_top #(
    parameter int              AW       = regport_pkg::DEF_AW,
    parameter int              DW       = regport_pkg::DEF_DW,
    parameter int              NREGS    = regport_pkg::DEF_NREGS,
    parameter logic [AW-1:0]   BASE_RST = regport_pkg::DEF_BASE_RST,
    parameter logic [AW-1:0]   BASE_A   = regport_pkg::DEF_BASE_A,
    parameter logic [AW-1:0]   BASE_B   = regport_pkg::DEF_BASE_B,
    parameter logic [AW-1:0]   BASE_C   = regport_pkg::DEF_BASE_C,
    parameter logic [AW-1:0]   BASE_D   = regport_pkg::DEF_BASE_D,
    localparam int             IW       = $clog2(NREGS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wdata,
    input  logic          io_wr,
    input  logic          io_rd,
    output logic [DW-1:0] io_rdata,
    output logic          io_hit,
    input  logic          run_en,
    input  logic          cfg_mode,
    input  logic          base_prog_we,
    input  logic [AW-1:0] base_prog_val,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata
);
    logic [AW-1:0] cur_base, dat_addr;
    logic          at_idx, at_dat, idx_ok, port_we;
    logic [IW-1:0] port_idx;
    logic [DW-1:0] port_rdata;
    logic [DW-1:0] idx_d, idx_q;

    regport_base #(
        .AW(AW), .BASE_RST(BASE_RST),
        .BASE_A(BASE_A), .BASE_B(BASE_B), .BASE_C(BASE_C), .BASE_D(BASE_D)
    ) u_base (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .prog_we  (base_prog_we),
        .prog_val (base_prog_val),
        .cur_base (cur_base)
    );

    regport_bank #(.DW(DW), .NREGS(NREGS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .port_we    (port_we),
        .port_idx   (port_idx),
        .port_wdata (io_wdata),
        .cfg_we     (cfg_we && cfg_mode),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .port_rdata (port_rdata),
        .cfg_rdata  (cfg_rdata)
    );

    always_comb begin
        dat_addr = cur_base + AW'(1);
        at_idx   = run_en && (io_addr == cur_base);
        at_dat   = run_en && (io_addr == dat_addr);
        idx_ok   = (idx_q != '0) && (idx_q <= DW'(NREGS));
        port_idx = idx_ok ? idx_q[IW-1:0] : '0;
        port_we  = io_wr && at_dat && idx_ok;

        idx_d = idx_q;
        if (io_wr && at_idx) idx_d = io_wdata;

        io_hit = (io_rd || io_wr) && (at_idx || at_dat);
        if (io_rd && at_idx)      io_rdata = idx_q;
        else if (io_rd && at_dat) io_rdata = idx_ok ? port_rdata : '0;
        else                      io_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

    // R2
    idx_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && run_en && io_addr == cur_base) |=> (idx_q == $past(io_wdata)));

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (io_rdata == '0 && !io_hit));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == '0));
endmodule

// File: tb/regport_top_bench.sv
`timescale 1ns/1ps
module regport_top_bench;
    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] io_addr = 0, io_wdata = 0, base_prog_val = 0, cfg_wdata = 0;
    logic       io_wr = 0, io_rd = 0, run_en = 1, cfg_mode = 0;
    logic       base_prog_we = 0, cfg_we = 0;
    logic [3:0] cfg_idx = 0;
    logic [7:0] io_rdata, cfg_rdata;
    logic       io_hit;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    regport_top u_regport_top (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_hit(io_hit),
        .run_en(run_en), .cfg_mode(cfg_mode), .base_prog_we(base_prog_we),
        .base_prog_val(base_prog_val), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic idle();
        io_wr = 0; io_rd = 0; base_prog_we = 0; cfg_we = 0;
    endtask

    task automatic io_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
        @(posedge clk); #1 idle();
    endtask

    task automatic io_read(logic [7:0] a, output logic [7:0] d, output logic h);
        @(negedge clk); io_addr = a; io_rd = 1;
        #1 d = io_rdata; h = io_hit;
        @(posedge clk); #1 idle();
    endtask

    task automatic cfg_write(logic [3:0] i, logic [7:0] d);
        @(negedge clk); cfg_idx = i; cfg_wdata = d; cfg_we = 1;
        @(posedge clk); #1 idle();
    endtask

    task automatic cfg_read(logic [3:0] i, output logic [7:0] d);
        @(negedge clk); cfg_idx = i;
        #1 d = cfg_rdata;
    endtask

    task automatic prog_base(logic [7:0] v);
        @(negedge clk); base_prog_val = v; base_prog_we = 1;
        @(posedge clk); #1 idle();
    endtask

    task automatic set_cfg(logic m);
        @(negedge clk); cfg_mode = m;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic h;
        io_read(8'hEA, d, h);
        check("R1 index after reset", d, 8'h00);
        check("R1 hit at reset base", {7'd0, h}, 8'h01);
        io_read(8'hEB, d, h);
        check("R1 data after reset", d, 8'h00);
        cfg_read(4'd5, d);
        check("R1 entry5 after reset", d, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] d; logic h;
        io_write(8'hEA, 8'h03);
        io_read(8'hEA, d, h);
        check("R2 index readback", d, 8'h03);
        io_write(8'hEB, 8'hA5);
        io_read(8'hEB, d, h);
        check("R3 entry3 via data port", d, 8'hA5);
        io_write(8'hEA, 8'h0F); io_write(8'hEB, 8'h3C);
        io_write(8'hEA, 8'h01); io_write(8'hEB, 8'h11);
        io_read(8'hEB, d, h);
        check("R3 entry1", d, 8'h11);
        io_write(8'hEA, 8'h0F);
        io_read(8'hEB, d, h);
        check("R3 entry15", d, 8'h3C);
        io_write(8'hEA, 8'h03);
        io_read(8'hEB, d, h);
        check("R3 entry3 kept", d, 8'hA5);
        cfg_read(4'd15, d);
        check("R3 entry15 via cfg path", d, 8'h3C);
    endtask

    task automatic t_range();
        logic [7:0] d; logic h;
        io_write(8'hEA, 8'h00); io_write(8'hEB, 8'h77);
        io_read(8'hEB, d, h);
        check("R4 index 00 reads zero", d, 8'h00);
        io_write(8'hEA, 8'h13); io_write(8'hEB, 8'h99);
        io_read(8'hEB, d, h);
        check("R4 index 13 reads zero", d, 8'h00);
        io_write(8'hEA, 8'hFF); io_write(8'hEB, 8'h55);
        cfg_read(4'd3, d);
        check("R4 entry3 untouched", d, 8'hA5);
        cfg_read(4'd15, d);
        check("R4 entry15 untouched", d, 8'h3C);
        cfg_read(4'd1, d);
        check("R4 entry1 untouched", d, 8'h11);
    endtask

    task automatic t_enable();
        logic [7:0] d; logic h;
        io_write(8'hEA, 8'h03);
        @(negedge clk); run_en = 0;
        io_read(8'hEA, d, h);
        check("R5 disabled rdata", d, 8'h00);
        check("R5 disabled hit", {7'd0, h}, 8'h00);
        io_write(8'hEA, 8'h05);
        io_write(8'hEB, 8'h00);
        @(negedge clk); run_en = 1;
        io_read(8'hEA, d, h);
        check("R5 index unchanged", d, 8'h03);
        io_read(8'hEB, d, h);
        check("R5 entry3 unchanged", d, 8'hA5);
    endtask

    task automatic t_base();
        logic [7:0] d; logic h;
        set_cfg(1);
        prog_base(8'hE4);
        io_read(8'hEA, d, h);
        check("R7 old base during cfg", d, 8'h03);
        io_read(8'hE4, d, h);
        check("R7 pending base not live", {7'd0, h}, 8'h00);
        prog_base(8'hE6);
        set_cfg(0);
        io_read(8'hE4, d, h);
        check("R6 illegal E6 ignored, E4 live", d, 8'h03);
        io_read(8'hE5, d, h);
        check("R7 data at E5", d, 8'hA5);
        io_read(8'hEA, d, h);
        check("R7 old base released", {7'd0, h}, 8'h00);
        prog_base(8'hE0);
        set_cfg(1); set_cfg(0);
        io_read(8'hE4, d, h);
        check("R6 run-mode prog ignored", d, 8'h03);
        set_cfg(1); prog_base(8'hE0); set_cfg(0);
        io_read(8'hE1, d, h);
        check("R7 data at E1", d, 8'hA5);
    endtask

    task automatic t_cfgpath();
        logic [7:0] d; logic h;
        set_cfg(1);
        cfg_write(4'd7, 8'h5A);
        cfg_read(4'd7, d);
        check("R8 cfg write/read", d, 8'h5A);
        cfg_write(4'd0, 8'hEE);
        cfg_read(4'd0, d);
        check("R8 cfg idx0 reads zero", d, 8'h00);
        set_cfg(0);
        io_write(8'hE0, 8'h07);
        io_read(8'hE1, d, h);
        check("R8 cfg data seen at port", d, 8'h5A);
        cfg_write(4'd7, 8'h66);
        cfg_read(4'd7, d);
        check("R8 cfg write outside cfg ignored", d, 8'h5A);
    endtask

    task automatic t_collide();
        logic [7:0] d; logic h;
        set_cfg(1);
        @(negedge clk);
        io_addr = 8'hE1; io_wdata = 8'h11; io_wr = 1;
        cfg_idx = 4'd7; cfg_wdata = 8'h22; cfg_we = 1;
        @(posedge clk); #1 idle();
        cfg_read(4'd7, d);
        check("R9 cfg wins same entry", d, 8'h22);
        io_write(8'hE0, 8'h08);
        @(negedge clk);
        io_addr = 8'hE1; io_wdata = 8'h33; io_wr = 1;
        cfg_idx = 4'd9; cfg_wdata = 8'h44; cfg_we = 1;
        @(posedge clk); #1 idle();
        cfg_read(4'd8, d);
        check("R9 port write lands", d, 8'h33);
        cfg_read(4'd9, d);
        check("R9 cfg write lands", d, 8'h44);
        set_cfg(0);
    endtask

    task automatic t_idle();
        @(negedge clk); io_addr = 8'hE0; io_wdata = 8'h08; io_wr = 1;
        #1;
        check("R10 write hit", {7'd0, io_hit}, 8'h01);
        check("R10 no rdata on write", io_rdata, 8'h00);
        @(posedge clk); #1 idle();
        @(negedge clk); io_addr = 8'hE1;
        #1;
        check("R10 idle hit", {7'd0, io_hit}, 8'h00);
        check("R10 idle rdata", io_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_basic();
        t_range();
        t_enable();
        t_base();
        t_cfgpath();
        t_collide();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule